// File: doc/BRIEF.md
# Micro-Op Driven Split-Bus Datapath

This block is the register-and-ALU core of a microcoded processor. It applies one micro-operation word on each clock. The word picks a source for the operand bus, an ALU function, and a set of destination registers. All chosen destinations load the result bus together on the rising clock edge. The microcode store and the instruction fetch sit outside the block, so the micro-op fields arrive as input ports.

Register 0 is the holding register. In the default two-bus build, this register is the only left operand the ALU can use. A two-operand sum therefore takes two micro-steps. The first step passes one operand through the ALU into the holding register. The second step adds the other operand, taken from the operand bus, and writes the result to its destination.

Setting `THREE_BUS` to 1 adds a second operand bus for the left ALU input, with its own selector. The same sum then finishes in one step. The operand bus can also carry an external word, which is how register contents are loaded. Zero and negative flags are registered together with each register write.

Top module: `ubus_datapath`

## Requirements
- R1: While `rst_ni` is low, every register reads 0 and both flags read 0.
- R2: A B-select value k below NUM_REGS (7) puts register k on the B bus. The value 7 puts `ext_data_i` on the B bus. `c_bus_o` shows the ALU result in the same cycle.
- R3: The ALU function codes are: 0 passes B, 1 gives A+B modulo 2^DATA_W, 2 gives A AND B, and 3 gives zero.
- R4: With THREE_BUS=0, the left operand A is always register 0, and `a_sel_i` has no effect.
- R5: With THREE_BUS=1, the left operand A is selected by `a_sel_i`, using the same encoding as the B select.
- R6: When `valid_i` is high, every register whose bit in `wr_en_i` is set (bit i for register i) loads C on the rising edge. Several registers may load at once, and registers whose bit is clear keep their value.
- R7: When `valid_i` is low, no register and no flag changes, whatever `wr_en_i` holds.
- R8: On a cycle with `valid_i` high and at least one write enable set, `zero_o` takes (C==0) and `neg_o` takes the MSB of C. On any other cycle both flags hold their value.
- R9: The sum of registers 1 and 2 written to register 3 takes two micro-steps in two-bus mode (pass into register 0, then add) and one step in three-bus mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; registers load on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Micro-op present this cycle |
| b_sel_i | input | SEL_W | B bus source select |
| a_sel_i | input | SEL_W | A bus source select (three-bus mode only) |
| alu_fn_i | input | 2 | ALU function code |
| wr_en_i | input | NUM_REGS | One C-bus load enable per register |
| ext_data_i | input | DATA_W | External word that the B bus can select |
| c_bus_o | output | DATA_W | ALU result bus |
| regs_o | output | NUM_REGS*DATA_W | All register contents; register i sits at bits [i*DATA_W +: DATA_W] |
| zero_o | output | 1 | Registered zero flag |
| neg_o | output | 1 | Registered negative flag |

## Verification
The assertions are checked on every cycle. They cover the following rules:
- an idle micro-op leaves every register unchanged;
- each enabled register captures the previous cycle's C value;
- the flags follow a written result;
- the pass-B and zero functions produce the expected result;
- in two-bus mode, an add uses the holding register.

Some behaviour only the bench scenarios can show:
- the exact values of the B-select decode, including the external source;
- sum wrap-around;
- simultaneous loads into several registers;
- flags holding across no-write cycles;
- the different results the two builds give for the same add sequence, which exposes whether `a_sel_i` is honoured or ignored.

// File: rtl/ubus_pkg.sv
package ubus_pkg;
  typedef enum logic [1:0] {
    FN_PASS_B = 2'd0,
    FN_ADD    = 2'd1,
    FN_AND    = 2'd2,
    FN_ZERO   = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic zero;
    logic neg;
  } flags_t;
endpackage

// File: rtl/ubus_src_mux.sv
module ubus_src_mux #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 7,
  parameter int unsigned SEL_W    = 3
) (
  input  logic [NUM_REGS*DATA_W-1:0] regs_i,
  input  logic [DATA_W-1:0]          ext_i,
  input  logic [SEL_W-1:0]           sel_i,
  output logic [DATA_W-1:0]          bus_o
);
  localparam logic [SEL_W-1:0] EXT_SEL = SEL_W'(NUM_REGS);

  always_comb begin
    bus_o = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (sel_i == SEL_W'(k)) bus_o = regs_i[k*DATA_W +: DATA_W];
    end
    if (sel_i == EXT_SEL) bus_o = ext_i;
  end
endmodule

// File: rtl/ubus_alu.sv
module ubus_alu
  import ubus_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  alu_fn_e           fn_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flags_o
);
  always_comb begin
    unique case (fn_i)
      FN_PASS_B: res_o = b_i;
      FN_ADD:    res_o = a_i + b_i;
      FN_AND:    res_o = a_i & b_i;
      default:   res_o = '0;
    endcase
  end

  assign flags_o.zero = (res_o == '0);
  assign flags_o.neg  = res_o[DATA_W-1];
endmodule

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NUM_REGS = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [NUM_REGS-1:0]        we_i,
  input  logic [DATA_W-1:0]          c_i,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_W-1:0] q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                q <= '0;
      else if (valid_i && we_i[i]) q <= c_i;
    end

    assign regs_o[i*DATA_W +: DATA_W] = q;

    // R6
    wr_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (valid_i && we_i[i]) |=> (q == $past(c_i)));
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(regs_o));
endmodule

// File: rtl/ubus_datapath.sv
module ubus_datapath
  import ubus_pkg::*;
#(
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned NUM_REGS  = 7,
  parameter bit          THREE_BUS = 1'b0,
  parameter int unsigned SEL_W     = $clog2(NUM_REGS + 1)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       valid_i,
  input  logic [SEL_W-1:0]           b_sel_i,
  input  logic [SEL_W-1:0]           a_sel_i,
  input  logic [1:0]                 alu_fn_i,
  input  logic [NUM_REGS-1:0]        wr_en_i,
  input  logic [DATA_W-1:0]          ext_data_i,
  output logic [DATA_W-1:0]          c_bus_o,
  output logic [NUM_REGS*DATA_W-1:0] regs_o,
  output logic                       zero_o,
  output logic                       neg_o
);
  logic [DATA_W-1:0] a_bus, b_bus, c_bus;
  flags_t            alu_flags, flags_q;
  alu_fn_e           fn;

  assign fn = alu_fn_e'(alu_fn_i);

  ubus_src_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_b_mux (
    .regs_i(regs_o), .ext_i(ext_data_i), .sel_i(b_sel_i), .bus_o(b_bus)
  );

  if (THREE_BUS) begin : g_three_bus
    ubus_src_mux #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .SEL_W(SEL_W)) u_a_mux (
      .regs_i(regs_o), .ext_i(ext_data_i), .sel_i(a_sel_i), .bus_o(a_bus)
    );
  end else begin : g_two_bus
    // left operand hard-wired to the holding register
    logic unused_a_sel;
    assign unused_a_sel = ^a_sel_i;
    assign a_bus = regs_o[0 +: DATA_W];

    // R4
    hold_left_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fn == FN_ADD) |-> (c_bus_o == DATA_W'(regs_o[0 +: DATA_W] + b_bus)));
  end

  ubus_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i(a_bus), .b_i(b_bus), .fn_i(fn), .res_o(c_bus), .flags_o(alu_flags)
  );

  ubus_regfile #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .we_i(wr_en_i),
    .c_i(c_bus), .regs_o(regs_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     flags_q <= '0;
    else if (valid_i && |wr_en_i)    flags_q <= alu_flags;
  end

  assign c_bus_o = c_bus;
  assign zero_o  = flags_q.zero;
  assign neg_o   = flags_q.neg;

  // R3
  pass_b_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == FN_PASS_B) |-> (c_bus_o == b_bus));

  // R3
  zero_fn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fn == FN_ZERO) |-> (c_bus_o == '0));

  // R8
  flag_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && |wr_en_i) |=>
      (zero_o == ($past(c_bus_o) == '0)) && (neg_o == $past(c_bus_o[DATA_W-1])));

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_i && |wr_en_i) |=> ($stable(zero_o) && $stable(neg_o)));
endmodule

// File: tb/ubus_datapath_tb.sv
`timescale 1ns/1ps
module ubus_datapath_tb;
  localparam int DW = 16;
  localparam int NR = 7;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid;
  logic [2:0] b_sel, a_sel;
  logic [1:0] fn;
  logic [NR-1:0] we;
  logic [DW-1:0] ext;
  logic [DW-1:0] c_o [2];
  logic [NR*DW-1:0] regs_o [2];
  logic zero_o [2], neg_o [2];

  always #2.5 clk = ~clk;

  ubus_datapath #(.DATA_W(DW), .NUM_REGS(NR), .THREE_BUS(1'b0)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .b_sel_i(b_sel), .a_sel_i(a_sel),
    .alu_fn_i(fn), .wr_en_i(we), .ext_data_i(ext), .c_bus_o(c_o[0]),
    .regs_o(regs_o[0]), .zero_o(zero_o[0]), .neg_o(neg_o[0]));

  ubus_datapath #(.DATA_W(DW), .NUM_REGS(NR), .THREE_BUS(1'b1)) u_dut3 (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid), .b_sel_i(b_sel), .a_sel_i(a_sel),
    .alu_fn_i(fn), .wr_en_i(we), .ext_data_i(ext), .c_bus_o(c_o[1]),
    .regs_o(regs_o[1]), .zero_o(zero_o[1]), .neg_o(neg_o[1]));

  typedef struct {
    int          dut;
    int          idx;   // 0..NR-1 register, NR zero flag, NR+1 neg flag
    logic [DW-1:0] val;
    string       req;
  } exp_t;

  exp_t sb_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_reg [2][NR];
  logic          m_zero [2], m_neg [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] src(input int d, input int sel, input logic [DW-1:0] e);
    if (sel < NR) return m_reg[d][sel];
    return e;
  endfunction

  function automatic logic [DW-1:0] alu(input int f, input logic [DW-1:0] a, input logic [DW-1:0] b);
    case (f)
      0: return b;
      1: return DW'(a + b);
      2: return a & b;
      default: return '0;
    endcase
  endfunction

  task automatic push_all(input string req);
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < NR; i++) sb_q.push_back('{d, i, m_reg[d][i], req});
      sb_q.push_back('{d, NR, DW'(m_zero[d]), req});
      sb_q.push_back('{d, NR + 1, DW'(m_neg[d]), req});
    end
  endtask

  task automatic step(input bit v, input int b, input int a, input int f,
                      input logic [NR-1:0] w, input logic [DW-1:0] e, input string req);
    logic [DW-1:0] cexp [2];
    @(negedge clk);
    valid = v; b_sel = 3'(b); a_sel = 3'(a); fn = 2'(f); we = w; ext = e;
    #1;
    for (int d = 0; d < 2; d++) begin
      logic [DW-1:0] opa;
      opa = (d == 0) ? m_reg[d][0] : src(d, a, e);
      cexp[d] = alu(f, opa, src(d, b, e));
      chk(c_o[d] === cexp[d], req, $sformatf("dut%0d c_bus", d), c_o[d], cexp[d]);
    end
    @(posedge clk);
    #1;
    if (v) begin
      for (int d = 0; d < 2; d++) begin
        for (int i = 0; i < NR; i++) if (w[i]) m_reg[d][i] = cexp[d];
        if (w != '0) begin
          m_zero[d] = (cexp[d] == '0);
          m_neg[d]  = cexp[d][DW-1];
        end
      end
    end
    push_all(req);
  endtask

  // monitor: compares registered outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t x;
        logic [DW-1:0] act;
        x = sb_q.pop_front();
        if (x.idx < NR)       act = regs_o[x.dut][x.idx*DW +: DW];
        else if (x.idx == NR) act = DW'(zero_o[x.dut]);
        else                  act = DW'(neg_o[x.dut]);
        chk(act === x.val, x.req, $sformatf("dut%0d item%0d", x.dut, x.idx), act, x.val);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    valid = 0; b_sel = 0; a_sel = 0; fn = 0; we = '0; ext = '0;
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < NR; i++) m_reg[d][i] = '0;
      m_zero[d] = 0; m_neg[d] = 0;
    end
    repeat (3) @(posedge clk);
    #1;
    push_all("R1");            // reset state, checked while still in reset
    @(negedge clk);
    #2;
    rst_ni = 1'b1;

    // R2: external loads through the B bus
    step(1, 7, 0, 0, 7'b0000010, 16'h1234, "R2");
    step(1, 7, 0, 0, 7'b0000100, 16'h8F00, "R2");
    // R6: two destinations loaded at once
    step(1, 7, 0, 0, 7'b0110000, 16'h00FF, "R6");
    // R2: register sources on B
    step(1, 4, 0, 0, 7'b0000000, 16'h0000, "R2");
    // R7: invalid op with enables set changes nothing
    step(0, 7, 0, 0, 7'b1111111, 16'hDEAD, "R7");
    // R9 / R4: two-bus sum of r1 + r2 into r3 (a_sel points at r4)
    step(1, 1, 4, 0, 7'b0000001, 16'h0000, "R9");
    step(1, 2, 4, 1, 7'b0001000, 16'h0000, "R4");
    // R5: single-step add in three-bus build, r1 + r2 into r6
    step(1, 2, 1, 1, 7'b1000000, 16'h0000, "R5");
    // R3: AND, with zero and neg flags
    step(1, 5, 2, 2, 7'b0100000, 16'h0000, "R3");
    step(1, 0, 0, 3, 7'b0010000, 16'h0000, "R3");
    // R8: no-write cycle holds flags
    step(1, 2, 0, 0, 7'b0000000, 16'h0000, "R8");
    // R3: wrap-around add -> zero flag
    step(1, 7, 0, 0, 7'b0000001, 16'hFFFF, "R3");
    step(1, 7, 7, 1, 7'b0000100, 16'h0001, "R3");
    step(1, 7, 0, 0, 7'b0000010, 16'h8000, "R8");
    repeat (3) @(negedge clk);

    // R9: final sums against constants
    chk(regs_o[0][3*DW +: DW] === 16'hA134, "R9", "two-bus sum reg3",
        regs_o[0][3*DW +: DW], 16'hA134);
    chk(regs_o[1][6*DW +: DW] === 16'hA134, "R9", "three-bus sum reg6",
        regs_o[1][6*DW +: DW], 16'hA134);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule